// File: doc/BRIEF.md
# Mailbox Receive Queue

This block is the receive side of an inter-processor mailbox. Remote cores deliver messages through a simple push port. Each message is a 64-bit payload tagged with the channel number of its sender. Messages wait in a first-in first-out queue of parameterised depth until the local processor takes them.

The local processor works through a 32-bit register port. It reads the oldest waiting message through three registers: payload low word, payload high word and source channel. It then writes a trigger register to discard that message and expose the next one.

Software does not get a fill count. It gets the raw read and write positions, which wrap at the queue depth, plus a separate full bit. From these it works out the fill level. The queue depth minus one is readable. A maskable interrupt tells the processor that messages are waiting, and a write of zero to the reset register empties the queue.

Top module: `mbx_rx_queue`

## Requirements
- R1: After reset the status register (0x14) reads 0, the interrupt mask (0x1C) reads 0x1F, the interrupt status (0x18) reads 0 and `irq` is low.
- R2: While the queue holds messages, offset 0x00 returns the oldest message's channel (zero-extended), 0x04 returns payload bits 31:0 and 0x08 returns payload bits 63:32; messages leave in arrival order.
- R3: A write to 0x0C with bit 0 set removes the oldest message and advances the read position by one, modulo DEPTH. A trigger write with bit 0 clear changes nothing. A trigger write on an empty queue changes nothing.
- R4: Status (0x14) holds the read position in bits 31:24, the write position in bits 23:16 and the full flag in bit 2, with every other bit zero; both positions wrap from DEPTH-1 to 0.
- R5: A queue with DEPTH entries reports full with equal positions. Its `push_accept` stays low, and a push into it leaves the positions and the head message unchanged.
- R6: Offset 0x24 reads DEPTH-1.
- R7: The mask register (0x1C) stores write bits 4:0 and reads zero above them.
- R8: At each clock edge, if the queue is non-empty and mask bit 0 is clear, interrupt status bit 0 becomes 1. `irq` equals that status bit ANDed with the inverse of mask bit 0.
- R9: Writing 1 to bit 0 of 0x18 clears the interrupt status only when the condition of R8 is false in that cycle; otherwise the bit remains set.
- R10: Writing 0 to 0x10 empties the queue, zeroes both positions and the full flag, and clears the interrupt status. A nonzero write to 0x10 has no effect.
- R11: A push and a trigger in the same cycle on a queue that is not full both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | A remote sender offers a message |
| push_data | input | 64 | Message payload |
| push_chan | input | CHW | Sender channel number |
| push_accept | output | 1 | Message is stored at this clock edge |
| reg_addr | input | 6 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Messages-waiting interrupt |

## Verification
A wrong read position shows up in the status bits 31:24 on the next read, and it also puts the wrong message at the head, so the channel and payload reads go wrong at once. A lost or wrong full flag has two visible effects: the status reads show bit 2 wrong at equal positions, and `push_accept` is wrong in the very cycle a ninth push is offered. A fault in the interrupt state shows on `irq` one clock after the queue becomes non-empty, after the mask changes, or after a clear write. That is why the reference model compares `irq`, `push_accept` and the addressed register on every cycle.

// File: rtl/mbx_rx_queue.sv
module mbx_rx_queue #(
  parameter int DEPTH = 8,
  parameter int CHW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_valid,
  input  logic [63:0]     push_data,
  input  logic [CHW-1:0]  push_chan,
  output logic            push_accept,
  input  logic [5:0]      reg_addr,
  input  logic            reg_wen,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [CHW+63:0] slot [DEPTH];
  logic [PW-1:0]   wr_ptr, rd_ptr;
  logic            full, irq_sts;
  logic [4:0]      irq_mask;
  logic [CHW+63:0] head;
  logic            empty, flush, pop, clr, mask_we, pend;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty       = (wr_ptr == rd_ptr) && !full;
  assign flush       = reg_wen && reg_addr == 6'h10 && reg_wdata == 32'd0;
  assign pop         = reg_wen && reg_addr == 6'h0C && reg_wdata[0] && !empty;
  assign clr         = reg_wen && reg_addr == 6'h18 && reg_wdata[0];
  assign mask_we     = reg_wen && reg_addr == 6'h1C;
  assign push_accept = push_valid && !full && !flush;
  assign pend        = !empty && !irq_mask[0];
  assign head        = slot[rd_ptr];
  assign irq         = irq_sts && !irq_mask[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      full     <= 1'b0;
      irq_sts  <= 1'b0;
      irq_mask <= 5'h1F;
    end else begin
      if (mask_we) irq_mask <= reg_wdata[4:0];
      if (flush) begin
        wr_ptr  <= '0;
        rd_ptr  <= '0;
        full    <= 1'b0;
        irq_sts <= 1'b0;
      end else begin
        if (pop) rd_ptr <= step(rd_ptr);
        if (push_accept) wr_ptr <= step(wr_ptr);
        if (push_accept && !pop && step(wr_ptr) == rd_ptr) full <= 1'b1;
        else if (pop && !push_accept) full <= 1'b0;
        irq_sts <= pend || (irq_sts && !clr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_accept) slot[wr_ptr] <= {push_chan, push_data};
  end

  always_comb begin
    case (reg_addr)
      6'h00:   reg_rdata = 32'(head[CHW+63:64]);
      6'h04:   reg_rdata = head[31:0];
      6'h08:   reg_rdata = head[63:32];
      6'h14:   reg_rdata = {8'(rd_ptr), 8'(wr_ptr), 13'd0, full, 2'd0};
      6'h18:   reg_rdata = {31'd0, irq_sts};
      6'h1C:   reg_rdata = {27'd0, irq_mask};
      6'h24:   reg_rdata = 32'(DEPTH - 1);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mbx_rx_queue_chk.sv
module mbx_rx_queue_chk #(
  parameter int DEPTH = 8,
  parameter int PW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          mask0,
  input logic [PW-1:0] wr_ptr,
  input logic [PW-1:0] rd_ptr,
  input logic          full,
  input logic          empty,
  input logic          irq_sts,
  input logic          flush,
  input logic          pop
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  // R3
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !flush |=> rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1));

  // R5
  p_full_ptrs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> wr_ptr == rd_ptr);

  // R5
  p_full_holds_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    full && !flush |=> $stable(wr_ptr));

  // R8
  p_irq_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mask0);

  // R9
  p_sts_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !empty && !mask0 && !flush |=> irq_sts);

  // R10
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> rd_ptr == '0 && wr_ptr == '0 && !full && !irq_sts);
endmodule

bind mbx_rx_queue mbx_rx_queue_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .mask0(irq_mask[0]),
  .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .full(full), .empty(empty),
  .irq_sts(irq_sts), .flush(flush), .pop(pop)
);

// File: tb/test_mbx_rx_queue.sv
module test_mbx_rx_queue;
  localparam int DEPTH = 8;
  localparam int CHW   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [63:0] push_data = '0;
  logic [CHW-1:0] push_chan = '0;
  logic push_accept;
  logic [5:0] reg_addr = '0;
  logic reg_wen = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mbx_rx_queue #(.DEPTH(DEPTH), .CHW(CHW)) i_mbx_rx_queue (
    .clk, .rst_n, .push_valid, .push_data, .push_chan, .push_accept,
    .reg_addr, .reg_wen, .reg_wdata, .reg_rdata, .irq);

  logic [CHW+63:0] q [$];
  int m_rd = 0, m_wr = 0;
  bit m_sts = 0;
  logic [4:0] m_mask = 5'h1F;

  function automatic logic [63:0] pat(input int n);
    return {32'hC0DE0000 + 32'(n), 32'h0000BEEF ^ 32'(n * 7)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_rd = 0; m_wr = 0; m_sts = 0; m_mask = 5'h1F;
    end else begin
      bit fl, pp, ac, cl, st;
      fl = reg_wen && reg_addr == 6'h10 && reg_wdata == 0;
      pp = reg_wen && reg_addr == 6'h0C && reg_wdata[0] && q.size() > 0;
      cl = reg_wen && reg_addr == 6'h18 && reg_wdata[0];
      ac = push_valid && q.size() < DEPTH && !fl;
      st = q.size() > 0 && !m_mask[0];
      if (reg_wen && reg_addr == 6'h1C) m_mask = reg_wdata[4:0];
      if (fl) begin
        q.delete(); m_rd = 0; m_wr = 0; m_sts = 0;
      end else begin
        if (pp) begin void'(q.pop_front()); m_rd = (m_rd + 1) % DEPTH; end
        if (ac) begin q.push_back({push_chan, push_data}); m_wr = (m_wr + 1) % DEPTH; end
        m_sts = st || (m_sts && !cl);
      end
    end
  end

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00, 6'h04, 6'h08: return "R2";
      6'h14: return "R4";
      6'h18: return "R9";
      6'h1C: return "R7";
      6'h24: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      begin
        logic [31:0] e;
        bit use_e;
        use_e = 1;
        case (reg_addr)
          6'h00: begin use_e = q.size() > 0; if (use_e) e = 32'(q[0][CHW+63:64]); end
          6'h04: begin use_e = q.size() > 0; if (use_e) e = q[0][31:0]; end
          6'h08: begin use_e = q.size() > 0; if (use_e) e = q[0][63:32]; end
          6'h14: e = {8'(m_rd), 8'(m_wr), 13'd0, q.size() == DEPTH, 2'd0};
          6'h18: e = {31'd0, m_sts};
          6'h1C: e = {27'd0, m_mask};
          6'h24: e = DEPTH - 1;
          default: e = 0;
        endcase
        if (use_e) cmp(tag_of(reg_addr), reg_rdata, e);
        cmp("R8 irq", 32'(irq), 32'(m_sts && !m_mask[0]));
        cmp("R5 accept", 32'(push_accept),
            32'(push_valid && q.size() < DEPTH && !(reg_wen && reg_addr == 6'h10 && reg_wdata == 0)));
      end
    end
  end

  task automatic cyc(input bit pv, input int n, input bit we, input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    push_valid = pv; push_data = pat(n); push_chan = CHW'(n);
    reg_wen = we; reg_addr = a; reg_wdata = d;
  endtask

  task automatic look(input logic [5:0] a, input logic [31:0] exp, input string tag);
    cyc(0, 0, 0, a, 0);
    #2 cmp(tag, reg_rdata, exp);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R6 depth
    look(6'h14, 32'h0, "R1 status");
    look(6'h1C, 32'h1F, "R1 mask");
    look(6'h18, 32'h0, "R1 irq status");
    #1 cmp("R1 irq", 32'(irq), 0);
    look(6'h24, 32'd7, "R6 depth");
    // R2 head and order
    for (int n = 1; n <= 3; n++) cyc(1, n, 0, 6'h14, 0);
    look(6'h00, 32'd1, "R2 chan");
    look(6'h04, pat(1) & 64'hFFFF_FFFF, "R2 low");
    look(6'h14, 32'h0003_0000, "R4 wr pos");
    // R8 unmask
    cyc(0, 0, 1, 6'h1C, 32'h1E);
    cyc(0, 0, 0, 6'h18, 0);
    look(6'h18, 32'h1, "R8 status set");
    #1 cmp("R8 irq high", 32'(irq), 1);
    // R9 clear refused while non-empty
    cyc(0, 0, 1, 6'h18, 1);
    look(6'h18, 32'h1, "R9 clear while pending");
    // R3 trigger with bit0 clear
    cyc(0, 0, 1, 6'h0C, 0);
    look(6'h14, 32'h0003_0000, "R3 trigger bit0 clear");
    cyc(0, 0, 1, 6'h0C, 1);
    look(6'h00, 32'd2, "R3 next head");
    look(6'h08, pat(2) >> 32, "R2 high");
    cyc(0, 0, 1, 6'h0C, 1);
    cyc(0, 0, 1, 6'h0C, 1);
    look(6'h14, 32'h0303_0000, "R4 positions");
    cyc(0, 0, 1, 6'h0C, 1);
    look(6'h14, 32'h0303_0000, "R3 trigger on empty");
    cyc(0, 0, 1, 6'h18, 1);
    look(6'h18, 32'h0, "R9 clear when drained");
    // R5 full
    for (int n = 10; n < 18; n++) cyc(1, n, 0, 6'h14, 0);
    look(6'h14, 32'h0303_0004, "R5 full status");
    cyc(1, 99, 0, 6'h14, 0);
    #2 cmp("R5 accept low when full", 32'(push_accept), 0);
    look(6'h14, 32'h0303_0004, "R5 rejected push");
    look(6'h00, 32'd2, "R5 head kept");
    // R5 push rejected even with pop in same cycle
    cyc(1, 50, 1, 6'h0C, 1);
    look(6'h14, 32'h0403_0000, "R5 pop from full");
    // R11 simultaneous push and pop
    cyc(1, 51, 1, 6'h0C, 1);
    look(6'h14, 32'h0504_0000, "R11 push and pop");
    look(6'h00, 32'd4, "R11 head");
    // R10 reset register
    cyc(0, 0, 1, 6'h10, 5);
    look(6'h14, 32'h0504_0000, "R10 nonzero ignored");
    cyc(0, 0, 1, 6'h10, 0);
    look(6'h14, 32'h0, "R10 flush positions");
    look(6'h18, 32'h0, "R10 flush irq status");
    // R7 mask width
    cyc(0, 0, 1, 6'h1C, 32'hFFFF_FFFF);
    look(6'h1C, 32'h1F, "R7 mask bits");
    // R4 wrap
    for (int n = 0; n < 11; n++) begin
      cyc(1, 60 + n, 0, 6'h00, 0);
      cyc(0, 0, 1, 6'h0C, 1);
    end
    look(6'h14, 32'h0303_0000, "R4 wrap");
    // mixed traffic under the per-cycle model
    cyc(0, 0, 1, 6'h1C, 32'h0);
    for (int n = 0; n < 60; n++)
      cyc((n % 3) != 0, 100 + n, (n % 4) == 1, (n % 4) == 1 ? 6'h0C : 6'((n % 3) * 4), 1);
    look(6'h18, 32'h1, "R8 busy traffic");
    repeat (2) @(negedge clk);
    summary();
  end
endmodule